// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is an I2C target that lets a bus master read and write a small file of 8-bit registers kept outside the block. The master reaches a register through an internal byte pointer: in a write transfer the first data byte sets the pointer and any further bytes are stored at the location it selects. To read, the master sets the pointer, then issues a repeated start with the read direction. From then on the slave sends bytes for as long as the master keeps acknowledging them.

SCL and SDA arrive as plain levels from the pads. They are resynchronised into the system clock, and the slave drives SDA only through an open-drain pull-down enable. A single select pin sets the lowest bit of the 7-bit device address, so two identical instances can share one bus. After each byte, the pointer moves forward only when it lies inside a configurable window. Past the top register it wraps to zero, and outside the window it stays where it is. The register file is attached through a plain port: address, write data, a one-cycle write strobe, and read data that is expected to be combinational from the address.

Top module: `i2c_regport_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start: it aborts any transfer and begins address reception. A rising SDA while SCL is high is a stop: it returns the slave to idle and releases SDA. A new transfer is accepted immediately after either condition.
- R2: Before the first start condition, SCL and SDA activity produces no acknowledge, no SDA drive and no register write.
- R3: The first byte after a start is the 7-bit device address, most significant bit first, followed by a direction bit: 0 selects write and 1 selects read.
- R4: When the received address equals `{DEV_ADDR[6:1], addr_sel}` (default 0x44 or 0x45), the slave pulls SDA low through the ninth clock. On any other address it does not drive SDA again until the next start, and no register is written.
- R5: SDA is sampled on the rising SCL edge. `sda_oe` changes only while SCL is low, apart from the release at a start or stop.
- R6: In a write transfer the first data byte loads the pointer. Each later byte raises `reg_we` for exactly one clock with that byte on `reg_wdata` and the pointer on `reg_addr`. Every data byte is acknowledged.
- R7: After a repeated start with the read bit set, the slave shifts out, most significant bit first, the register at the current pointer.
- R8: In a read, a low SDA at the ninth clock makes the slave send the next byte. A high SDA makes it release SDA and return to idle.
- R9: Inside the window `INC_FIRST..INC_LAST` (default 0x04..0x0F), the pointer advances by one after every byte read or written. Past `TOP_REG` (default 0x0F) it wraps to 0x00.
- R10: Outside the window, the pointer does not move, so repeated bytes all access the same register.
- R11: `addr_sel` picks between the two device addresses: with `addr_sel`=1 the slave answers 0x45 and ignores 0x44.
- R12: During and right after reset, `sda_oe` and `reg_we` are 0 and `reg_addr` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| addr_sel | input | 1 | Lowest device-address bit |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Byte to store |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Combinational read data at `reg_addr` |

## Verification
The assertions assume a well-behaved master. SDA changes only while SCL is low, except for deliberate start and stop conditions. Each SCL phase lasts more than the three-clock synchroniser and edge latency, and the master never issues a start or stop while the slave is driving a data bit. The bench master meets these rules: it holds each SCL phase for 16 system clocks and waits half a phase after every SCL fall before moving SDA. As a result, every slave update settles before the next rising edge samples it.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

  localparam int REG_AW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WRX,
    ST_TX,
    ST_MACK
  } rp_state_e;

  // pointer after one access: moves only inside [lo, hi], wraps past last
  function automatic logic [REG_AW-1:0] ptr_next(input logic [REG_AW-1:0] p,
                                                 input logic [REG_AW-1:0] lo,
                                                 input logic [REG_AW-1:0] hi,
                                                 input logic [REG_AW-1:0] last);
    if (p < lo || p > hi) return p;
    if (p == last) return '0;
    return p + 1'b1;
  endfunction

  // device address compare: upper six bits fixed, lowest bit from the pin
  function automatic logic addr_hit(input logic [5:0] upper,
                                    input logic       sel,
                                    input logic [6:0] got);
    return {upper, sel} == got;
  endfunction

endpackage

// File: rtl/i2c_rp_busmon.sv
module i2c_rp_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] scl_q;
  logic [DEPTH-1:0] sda_q;

  // synchroniser chain plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[DEPTH-2:0], scl_i};
      sda_q <= {sda_q[DEPTH-2:0], sda_i};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_hi   = scl_q[DEPTH-2];
  assign sda_hi   = sda_q[DEPTH-2];
  assign scl_prev = scl_q[DEPTH-1];
  assign sda_prev = sda_q[DEPTH-1];

  assign scl_rise = scl_hi & ~scl_prev;
  assign scl_fall = ~scl_hi & scl_prev;
  assign ev_start = scl_hi & scl_prev & sda_prev & ~sda_hi;
  assign ev_stop  = scl_hi & scl_prev & ~sda_prev & sda_hi;

endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr
  import i2c_rp_pkg::*;
#(
  parameter logic [REG_AW-1:0] INC_FIRST = 8'h04,
  parameter logic [REG_AW-1:0] INC_LAST  = 8'h0F,
  parameter logic [REG_AW-1:0] TOP_REG   = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [REG_AW-1:0] load_val,
  input  logic              step,
  output logic [REG_AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr_next(ptr, INC_FIRST, INC_LAST, TOP_REG);
  end

  // R9: stepping from the top register inside the window lands on zero
  p_wrap_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ptr == TOP_REG && TOP_REG >= INC_FIRST && TOP_REG <= INC_LAST)
      |=> ptr == '0);

  // R10: stepping outside the window leaves the pointer untouched
  p_hold_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (ptr < INC_FIRST || ptr > INC_LAST)) |=> $stable(ptr));

endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
  import i2c_rp_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h44,
  parameter logic [REG_AW-1:0] INC_FIRST   = 8'h04,
  parameter logic [REG_AW-1:0] INC_LAST    = 8'h0F,
  parameter logic [REG_AW-1:0] TOP_REG     = 8'h0F,
  parameter int                SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  // named bus events, shared by the FSM and the assertions
  logic scl_hi, sda_hi, scl_rise, scl_fall, ev_start, ev_stop;

  i2c_rp_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_hi   (scl_hi),
    .sda_hi   (sda_hi),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop)
  );

  rp_state_e         st;
  logic [2:0]        bitcnt;
  logic [6:0]        rx_sh;
  logic [6:0]        tx_sh;
  logic              is_read, first_wr, ack_on, mack_ok;
  logic              oe_q, we_q;
  logic [7:0]        wdata_q;
  logic [REG_AW-1:0] ptr;

  logic [7:0] rx_byte;
  logic       rx_done, addr_ok, ptr_load, tx_load, ptr_step;

  assign rx_byte  = {rx_sh, sda_hi};
  assign rx_done  = scl_rise && bitcnt == 3'd7 && (st == ST_ADDR || st == ST_WRX);
  assign addr_ok  = addr_hit(DEV_ADDR[6:1], addr_sel, rx_byte[7:1]);
  assign ptr_load = rx_done && st == ST_WRX && first_wr;
  assign tx_load  = scl_fall && ((st == ST_ACK && ack_on && is_read) ||
                                 (st == ST_MACK && mack_ok));
  assign ptr_step = we_q || tx_load;

  i2c_rp_ptr #(
    .INC_FIRST (INC_FIRST),
    .INC_LAST  (INC_LAST),
    .TOP_REG   (TOP_REG)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (rx_byte),
    .step     (ptr_step),
    .ptr      (ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      is_read  <= 1'b0;
      first_wr <= 1'b0;
      ack_on   <= 1'b0;
      mack_ok  <= 1'b0;
      oe_q     <= 1'b0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
    end else begin
      we_q <= 1'b0;
      if (ev_start) begin
        st      <= ST_ADDR;
        bitcnt  <= '0;
        oe_q    <= 1'b0;
        ack_on  <= 1'b0;
        mack_ok <= 1'b0;
      end else if (ev_stop) begin
        st      <= ST_IDLE;
        oe_q    <= 1'b0;
        ack_on  <= 1'b0;
        mack_ok <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: if (scl_rise) begin
            rx_sh  <= rx_byte[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              if (addr_ok) begin
                st       <= ST_ACK;
                is_read  <= rx_byte[0];
                first_wr <= ~rx_byte[0];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_WRX: if (scl_rise) begin
            rx_sh  <= rx_byte[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              st       <= ST_ACK;
              first_wr <= 1'b0;
              if (!first_wr) begin
                we_q    <= 1'b1;
                wdata_q <= rx_byte;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              oe_q   <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              bitcnt <= '0;
              if (is_read) begin
                st    <= ST_TX;
                tx_sh <= reg_rdata[6:0];
                oe_q  <= ~reg_rdata[7];
              end else begin
                st   <= ST_WRX;
                oe_q <= 1'b0;
              end
            end
          end
          ST_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              oe_q    <= 1'b0;
              st      <= ST_MACK;
              mack_ok <= 1'b0;
            end else begin
              tx_sh  <= {tx_sh[5:0], 1'b0};
              oe_q   <= ~tx_sh[6];
              bitcnt <= bitcnt + 3'd1;
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_hi) st <= ST_IDLE;
              else        mack_ok <= 1'b1;
            end else if (scl_fall && mack_ok) begin
              mack_ok <= 1'b0;
              st      <= ST_TX;
              bitcnt  <= '0;
              tx_sh   <= reg_rdata[6:0];
              oe_q    <= ~reg_rdata[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;

  // R5: the pull-down moves only in an SCL low phase, or at a start/stop release
  p_sda_low_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> (!$past(scl_hi) || $past(ev_start) || $past(ev_stop)));

  // R4: an idle slave never holds SDA
  p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !oe_q);

  // R6: a write strobe is a single-cycle pulse
  p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R8: a high SDA at the master-acknowledge clock ends the read
  p_nack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MACK && scl_rise && sda_hi && !ev_start && !ev_stop)
      |=> (st == ST_IDLE && !oe_q));

endmodule

// File: tb/i2c_regport_slave_test.sv
module i2c_regport_slave_test;
  localparam int         HALF = 16;
  localparam logic [6:0] DEV  = 7'h44;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, scl_m, sda_m, addr_sel;
  logic       sda_oe, reg_we, sda_line;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] regs [16];
  logic [7:0] shadow [16];

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = regs[reg_addr[3:0]];

  always @(posedge clk) if (reg_we) regs[reg_addr[3:0]] <= reg_wdata;

  i2c_regport_slave uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .addr_sel  (addr_sel),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  int checks = 0, errors = 0, oe_cnt = 0, r5_bad = 0, we_cnt = 0;
  logic last_oe = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (sda_oe) oe_cnt++;
    if (reg_we) we_cnt++;
    if (sda_oe !== last_oe && scl_m) r5_bad++;
    last_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // window 0x04..0x0F, wrap after 0x0F
  function automatic logic [7:0] exp_next(input logic [7:0] p);
    if (p >= 8'h04 && p <= 8'h0F) return (p == 8'h0F) ? 8'h00 : p + 8'h01;
    return p;
  endfunction

  task automatic qw(); repeat (HALF/2) @(negedge clk); endtask
  task automatic hw(); repeat (HALF) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; hw(); scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); acked = !sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_m = 1'b1; qw(); b[i] = sda_line; qw(); scl_m = 1'b0; qw();
    end
    sda_m = !give_ack; qw(); scl_m = 1'b1; hw(); scl_m = 1'b0; qw(); sda_m = 1'b1;
  endtask

  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];

  task automatic do_write(input logic [6:0] dev, input logic [7:0] p, input int n,
                          output bit all_ack);
    bit a;
    logic [7:0] q;
    all_ack = 1'b1;
    bus_start();
    send_byte({dev, 1'b0}, a); all_ack &= a;
    send_byte(p, a); all_ack &= a;
    q = p;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); all_ack &= a;
      shadow[q[3:0]] = wbuf[k];
      q = exp_next(q);
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] dev, input logic [7:0] p, input int n,
                         output bit all_ack);
    bit a;
    all_ack = 1'b1;
    bus_start();
    send_byte({dev, 1'b0}, a); all_ack &= a;
    send_byte(p, a); all_ack &= a;
    bus_start();
    send_byte({dev, 1'b1}, a); all_ack &= a;
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    bus_stop();
  endtask

  localparam logic [15:0] VEC [8] = '{16'h005A, 16'h03C3, 16'h04A5, 16'h0911,
                                      16'h0FFE, 16'h0201, 16'h077E, 16'h0C80};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [7:0] p;
    for (int i = 0; i < 16; i++) begin
      regs[i]   = 8'h10 + 8'(i);
      shadow[i] = 8'h10 + 8'(i);
    end
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; addr_sel = 1'b0;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R12 sda_oe in reset", sda_oe, 0);
    chk(reg_we == 1'b0, "R12 reg_we in reset", reg_we, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(reg_addr == 8'h00, "R12 pointer after reset", reg_addr, 0);

    // R2: a full address byte without any start
    oe_cnt = 0;
    scl_m = 1'b0; qw();
    send_byte({DEV, 1'b0}, ok);
    chk(!ok, "R2 no ack before start", ok, 0);
    chk(oe_cnt == 0, "R2 SDA untouched before start", oe_cnt, 0);
    bus_stop();

    // table: single write then random read back
    for (int v = 0; v < 8; v++) begin
      wbuf[0] = VEC[v][7:0];
      do_write(DEV, VEC[v][15:8], 1, ok);
      chk(ok, "R6 write bytes acknowledged", ok, 1);
      chk(regs[VEC[v][11:8]] == VEC[v][7:0], "R6 register stored", regs[VEC[v][11:8]], VEC[v][7:0]);
      do_read(DEV, VEC[v][15:8], 1, ok);
      chk(ok, "R3 R4 address acknowledged for both directions", ok, 1);
      chk(rbuf[0] == VEC[v][7:0], "R7 read returns pointed register", rbuf[0], VEC[v][7:0]);
      chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
    end

    // R9: sequential write across the wrap point
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    we_cnt = 0;
    do_write(DEV, 8'h0E, 3, ok);
    chk(we_cnt == 3, "R6 one strobe per data byte", we_cnt, 3);
    chk(regs[14] == 8'hA1, "R9 seq write reg 0x0E", regs[14], 8'hA1);
    chk(regs[15] == 8'hB2, "R9 seq write reg 0x0F", regs[15], 8'hB2);
    chk(regs[0] == 8'hC3, "R9 wrap to 0x00 on write", regs[0], 8'hC3);

    // R8/R9: sequential read across the wrap point
    do_read(DEV, 8'h0E, 3, ok);
    p = 8'h0E;
    for (int k = 0; k < 3; k++) begin
      chk(rbuf[k] == shadow[p[3:0]], "R8 R9 sequential read", rbuf[k], shadow[p[3:0]]);
      p = exp_next(p);
    end

    // R10: pointer fixed outside the window
    wbuf[0] = 8'h33; wbuf[1] = 8'h44;
    do_write(DEV, 8'h02, 2, ok);
    chk(regs[2] == 8'h44, "R10 last byte lands on same register", regs[2], 8'h44);
    chk(regs[3] == shadow[3], "R10 neighbour untouched", regs[3], shadow[3]);
    do_read(DEV, 8'h01, 3, ok);
    for (int k = 0; k < 3; k++)
      chk(rbuf[k] == shadow[1], "R10 repeated read same register", rbuf[k], shadow[1]);

    // R4: wrong address is ignored for the whole transfer
    oe_cnt = 0;
    bus_start();
    send_byte({7'h48, 1'b0}, ok);
    chk(!ok, "R4 no ack on other address", ok, 0);
    send_byte(8'h01, ok);
    send_byte(8'hEE, ok);
    bus_stop();
    chk(oe_cnt == 0, "R4 SDA never driven after mismatch", oe_cnt, 0);
    chk(regs[1] == shadow[1], "R4 no write after mismatch", regs[1], shadow[1]);

    // R11: select pin moves the device address
    addr_sel = 1'b1;
    repeat (4) @(negedge clk);
    bus_start();
    send_byte({DEV, 1'b0}, ok);
    bus_stop();
    chk(!ok, "R11 old address ignored", ok, 0);
    wbuf[0] = 8'h6D;
    do_write(7'h45, 8'h05, 1, ok);
    chk(ok, "R11 alternate address acknowledged", ok, 1);
    chk(regs[5] == 8'h6D, "R11 write through alternate address", regs[5], 8'h6D);
    addr_sel = 1'b0;
    repeat (4) @(negedge clk);

    // R1: stop mid-transfer, then a fresh transfer works
    bus_start();
    send_byte({DEV, 1'b0}, ok);
    bus_stop();
    chk(sda_oe == 1'b0, "R1 stop releases bus", sda_oe, 0);
    do_read(DEV, 8'h05, 1, ok);
    chk(ok && rbuf[0] == 8'h6D, "R1 transfer after stop", rbuf[0], 8'h6D);

    chk(r5_bad == 0, "R5 SDA drive changed while SCL high", r5_bad, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule